// File: doc/BRIEF.md
# Overlay window pixel compositor

This block sits in the pixel path of a display pipeline and merges two rectangular overlay planes with a base plane. A raster timing generator supplies the x/y position of every base pixel, an active flag for the visible region and a frame start pulse. The block decides for each position whether either overlay window covers it. It outputs the composited pixel one clock later. It also raises a request strobe for each covering overlay, which the fetch logic of that overlay uses to step to its next pixel. Overlay pixels arrive already in the base pixel format.

Each overlay is set up by two 32-bit control words. The first holds the window size, a bits-per-pixel code and the enable. The second holds the start position and, for overlay 2 only, a source format. The block checks each configuration against the base plane size and the 32-bit word alignment rule. A configuration that fails is flagged and its window stays hidden. All settings, including a global bit that puts the overlays above or below the base plane, are captured at the frame start pulse, so a frame never mixes old and new settings.

Top module: `ovl_compositor`

## Requirements
- R1: In control word 1, bits 9:0 hold the window width minus one, bits 19:10 the height minus one, bits 23:20 a bits-per-pixel code and bit 31 the enable. A position (x, y) is covered when XS <= x <= XS + width field and YS <= y <= YS + height field, both limits inclusive.
- R2: In control word 2, bits 9:0 hold the start column XS and bits 19:10 the start row YS. On overlay 2 only, bits 22:20 hold a source format: 0 RGB, 1 packed 4:4:4, 2 planar 4:4:4, 3 planar 4:2:2, 4 planar 4:2:0. Formats 1..4 count as 24, 8, 4 and 2 bits per pixel. For format 0, code 0..7 of the bits-per-pixel field means 1, 2, 4, 8, 16, 18, 24 and 32 bits, and codes 8..15 are illegal.
- R3: A configuration is an error when overlay 1 has a nonzero value in bits 22:20 of control word 2, when overlay 2 has a format above 4, or when the format-0 code is illegal.
- R4: A configuration is an error when XS + width > base width or when YS + height > base height. Width and height here are the field values plus one, and an exact fit is legal.
- R5: A configuration is an error when XS times its bits per pixel is not a multiple of 32.
- R6: An enabled overlay with an erroneous configuration sets its bit of `cfg_err_o` (bit 0 overlay 1, bit 1 overlay 2) and covers no pixel. A disabled overlay covers nothing and never flags an error.
- R7: In above mode (`ovl_above_i` = 1 captured), the output is the overlay 2 pixel where overlay 2 covers and its valid flag is high. Otherwise it is the overlay 1 pixel where overlay 1 covers and is valid. Otherwise it is the base pixel.
- R8: In below mode, the output is always the base pixel, and the request strobes still follow coverage.
- R9: `req_o[k]` is high exactly for active positions that overlay k covers, whatever its valid flag. Outside the active region both strobes are low and the output is the base pixel.
- R10: `px_o` and `req_o` appear on the clock edge after the position, pixels and flags are presented.
- R11: Control words, base size and mode are sampled only on a clock edge where `frame_start_i` is high, which must lie outside the active region. Changes at any other time have no effect on the output until the next such edge. `cfg_err_o` updates on that edge.
- R12: After reset `px_o`, `req_o` and `cfg_err_o` are zero, both overlays are hidden and below mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame start pulse; captures all settings |
| active_i | input | 1 | Position lies in the visible region |
| x_i | input | 10 | Raster column |
| y_i | input | 10 | Raster row |
| base_w_i | input | 11 | Base plane width in pixels |
| base_h_i | input | 11 | Base plane height in lines |
| ovl_above_i | input | 1 | 1: overlays above base, 0: below |
| ov1_ctl1_i | input | 32 | Overlay 1 control word 1 |
| ov1_ctl2_i | input | 32 | Overlay 1 control word 2 |
| ov2_ctl1_i | input | 32 | Overlay 2 control word 1 |
| ov2_ctl2_i | input | 32 | Overlay 2 control word 2 |
| base_px_i | input | PIX_W | Base plane pixel |
| ov1_px_i | input | PIX_W | Overlay 1 pixel |
| ov2_px_i | input | PIX_W | Overlay 2 pixel |
| ov1_vld_i | input | 1 | Overlay 1 pixel valid |
| ov2_vld_i | input | 1 | Overlay 2 pixel valid |
| px_o | output | PIX_W | Composited pixel |
| req_o | output | 2 | Per-overlay pixel request strobe |
| cfg_err_o | output | 2 | Per-overlay configuration error |

## Verification
A wrong captured window shows at the ports on the very next active pixel near its edge. A bad limit or an off-by-one in the inclusive compare shifts a request strobe and the chosen pixel by one column or row, so the bench sweeps each window border and its neighbours. A wrong validity verdict appears in `cfg_err_o` one cycle after the frame start pulse, and the first covered pixel then either shows overlay data that should be hidden or the reverse. A capture that leaks outside the frame start pulse shows as output changing in mid-frame right after the control inputs move.

// File: rtl/ovl_comp_pkg.sv
package ovl_comp_pkg;
  localparam int unsigned COORD_W    = 10;
  localparam int unsigned SIZE_W     = COORD_W + 1;
  localparam int unsigned CTL_W      = 32;
  localparam int unsigned BCODE_W    = 4;
  localparam int unsigned FMT_W      = 3;
  localparam int unsigned BPP_W      = 6;
  localparam int unsigned ALIGN_BITS = 5;   // 32-bit word
  localparam int unsigned N_OVL      = 2;

  // control word 1
  localparam int unsigned C1_W_LSB   = 0;
  localparam int unsigned C1_H_LSB   = 10;
  localparam int unsigned C1_BPP_LSB = 20;
  localparam int unsigned C1_EN_BIT  = 31;
  // control word 2
  localparam int unsigned C2_X_LSB   = 0;
  localparam int unsigned C2_Y_LSB   = 10;
  localparam int unsigned C2_FMT_LSB = 20;

  typedef enum logic [FMT_W-1:0] {
    FMT_RGB       = 3'd0,
    FMT_Y444_PACK = 3'd1,
    FMT_Y444_PLAN = 3'd2,
    FMT_Y422_PLAN = 3'd3,
    FMT_Y420_PLAN = 3'd4
  } src_fmt_e;

  typedef struct packed {
    logic              on;
    logic [SIZE_W-1:0] x_lo;
    logic [SIZE_W-1:0] x_hi;
    logic [SIZE_W-1:0] y_lo;
    logic [SIZE_W-1:0] y_hi;
  } win_t;

  // {legal, bits per pixel}
  function automatic logic [BPP_W:0] eff_bpp(input logic [FMT_W-1:0]   fmt,
                                             input logic [BCODE_W-1:0] code);
    logic [BPP_W:0] r;
    r = '0;
    case (src_fmt_e'(fmt))
      FMT_RGB: begin
        if (code < 4'd5)       r = {1'b1, BPP_W'(1) << code};
        else if (code == 4'd5) r = {1'b1, BPP_W'(18)};
        else if (code == 4'd6) r = {1'b1, BPP_W'(24)};
        else if (code == 4'd7) r = {1'b1, BPP_W'(32)};
      end
      FMT_Y444_PACK: r = {1'b1, BPP_W'(24)};
      FMT_Y444_PLAN: r = {1'b1, BPP_W'(8)};
      FMT_Y422_PLAN: r = {1'b1, BPP_W'(4)};
      FMT_Y420_PLAN: r = {1'b1, BPP_W'(2)};
      default:       r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ovl_cfg_shadow.sv
module ovl_cfg_shadow
  import ovl_comp_pkg::*;
#(
  parameter bit HAS_FMT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTL_W-1:0]  ctl1_i,
  input  logic [CTL_W-1:0]  ctl2_i,
  input  logic [SIZE_W-1:0] base_w_i,
  input  logic [SIZE_W-1:0] base_h_i,
  output win_t              win_o,
  output logic              err_o
);
  localparam int unsigned PROD_W = COORD_W + BPP_W;

  logic [COORD_W-1:0] w_m1, h_m1, xs, ys;
  logic [BCODE_W-1:0] bcode;
  logic [FMT_W-1:0]   fmt;
  logic               en;
  logic [BPP_W:0]     bpp_v;
  logic [PROD_W-1:0]  xbits;
  logic [SIZE_W-1:0]  x_end, y_end;
  logic               fmt_bad, bpp_ok, align_ok, fit_ok, bad;
  logic               unused_bits;

  assign w_m1  = ctl1_i[C1_W_LSB +: COORD_W];
  assign h_m1  = ctl1_i[C1_H_LSB +: COORD_W];
  assign bcode = ctl1_i[C1_BPP_LSB +: BCODE_W];
  assign en    = ctl1_i[C1_EN_BIT];
  assign xs    = ctl2_i[C2_X_LSB +: COORD_W];
  assign ys    = ctl2_i[C2_Y_LSB +: COORD_W];
  assign fmt   = ctl2_i[C2_FMT_LSB +: FMT_W];
  assign unused_bits = ^{ctl1_i[30:24], ctl2_i[31:23]};

  // overlay without a format field must see zero there
  assign fmt_bad  = !HAS_FMT && (fmt != '0);
  assign bpp_v    = eff_bpp(fmt, bcode);
  assign bpp_ok   = bpp_v[BPP_W] && !fmt_bad;
  assign xbits    = PROD_W'(xs) * PROD_W'(bpp_v[BPP_W-1:0]);
  assign align_ok = (xbits[ALIGN_BITS-1:0] == '0);

  assign x_end  = SIZE_W'(xs) + SIZE_W'(w_m1);
  assign y_end  = SIZE_W'(ys) + SIZE_W'(h_m1);
  assign fit_ok = (x_end < base_w_i) && (y_end < base_h_i);
  assign bad    = !bpp_ok || !align_ok || !fit_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_o <= '0;
      err_o <= 1'b0;
    end else if (load_i) begin
      win_o.on   <= en && !bad;
      win_o.x_lo <= SIZE_W'(xs);
      win_o.x_hi <= x_end;
      win_o.y_lo <= SIZE_W'(ys);
      win_o.y_hi <= y_end;
      err_o      <= en && bad;
    end
  end

  // R11: captured window only moves on a load
  a_r11_hold_between_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(win_o) && $stable(err_o));

  // R4: oversize window is flagged and hidden
  a_r4_oversize_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && en && (SIZE_W'(xs) + SIZE_W'(w_m1) >= base_w_i) |=> err_o && !win_o.on);

  // R6: disabled overlay never flags
  a_r6_off_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !en |=> !err_o && !win_o.on);

  if (!HAS_FMT) begin : g_no_fmt
    // R3: overlay without format field accepts only zero there
    a_r3_fmt_must_be_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i && en && (ctl2_i[C2_FMT_LSB +: FMT_W] != '0) |=> err_o);
  end
endmodule

// File: rtl/ovl_window_hit.sv
module ovl_window_hit
  import ovl_comp_pkg::*;
(
  input  win_t               win_i,
  input  logic               active_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic               hit_o
);
  logic [SIZE_W-1:0] xe, ye;
  assign xe = SIZE_W'(x_i);
  assign ye = SIZE_W'(y_i);

  // inclusive limits: stored size is already minus one
  assign hit_o = win_i.on && active_i &&
                 (xe >= win_i.x_lo) && (xe <= win_i.x_hi) &&
                 (ye >= win_i.y_lo) && (ye <= win_i.y_hi);
endmodule

// File: rtl/ovl_pix_mux.sv
module ovl_pix_mux
  import ovl_comp_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic                        above_i,
  input  logic [N_OVL-1:0]            hit_i,
  input  logic [N_OVL-1:0]            vld_i,
  input  logic [N_OVL-1:0][PIX_W-1:0] ovl_px_i,
  input  logic [PIX_W-1:0]            base_px_i,
  output logic [PIX_W-1:0]            px_o
);
  // later index overrides: highest overlay on top
  always_comb begin
    px_o = base_px_i;
    for (int k = 0; k < N_OVL; k++) begin
      if (above_i && hit_i[k] && vld_i[k]) px_o = ovl_px_i[k];
    end
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_comp_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               active_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [SIZE_W-1:0]  base_w_i,
  input  logic [SIZE_W-1:0]  base_h_i,
  input  logic               ovl_above_i,
  input  logic [CTL_W-1:0]   ov1_ctl1_i,
  input  logic [CTL_W-1:0]   ov1_ctl2_i,
  input  logic [CTL_W-1:0]   ov2_ctl1_i,
  input  logic [CTL_W-1:0]   ov2_ctl2_i,
  input  logic [PIX_W-1:0]   base_px_i,
  input  logic [PIX_W-1:0]   ov1_px_i,
  input  logic [PIX_W-1:0]   ov2_px_i,
  input  logic               ov1_vld_i,
  input  logic               ov2_vld_i,
  output logic [PIX_W-1:0]   px_o,
  output logic [N_OVL-1:0]   req_o,
  output logic [N_OVL-1:0]   cfg_err_o
);
  logic [N_OVL-1:0][CTL_W-1:0] ctl1_a, ctl2_a;
  logic [N_OVL-1:0][PIX_W-1:0] ovl_px_a;
  logic [N_OVL-1:0]            vld_a, hit_a, err_a;
  win_t                        win_a [N_OVL];
  logic                        above_q, seen_q;
  logic [PIX_W-1:0]            px_d;

  assign ctl1_a   = {ov2_ctl1_i, ov1_ctl1_i};
  assign ctl2_a   = {ov2_ctl2_i, ov1_ctl2_i};
  assign ovl_px_a = {ov2_px_i, ov1_px_i};
  assign vld_a    = {ov2_vld_i, ov1_vld_i};

  for (genvar k = 0; k < N_OVL; k++) begin : g_ovl
    ovl_cfg_shadow #(.HAS_FMT(k != 0)) i_shadow (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (frame_start_i),
      .ctl1_i   (ctl1_a[k]),
      .ctl2_i   (ctl2_a[k]),
      .base_w_i (base_w_i),
      .base_h_i (base_h_i),
      .win_o    (win_a[k]),
      .err_o    (err_a[k])
    );

    ovl_window_hit i_hit (
      .win_i    (win_a[k]),
      .active_i (active_i),
      .x_i      (x_i),
      .y_i      (y_i),
      .hit_o    (hit_a[k])
    );
  end

  ovl_pix_mux #(.PIX_W(PIX_W)) i_mux (
    .above_i   (above_q),
    .hit_i     (hit_a),
    .vld_i     (vld_a),
    .ovl_px_i  (ovl_px_a),
    .base_px_i (base_px_i),
    .px_o      (px_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      seen_q  <= 1'b0;
      px_o    <= '0;
      req_o   <= '0;
    end else begin
      seen_q <= 1'b1;
      if (frame_start_i) above_q <= ovl_above_i;
      px_o  <= px_d;
      req_o <= hit_a;
    end
  end

  assign cfg_err_o = err_a;

  // R11: frame start only in blanking
  a_r11_start_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> !active_i);

  // R9: no request outside the visible region
  a_r9_req_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (req_o != '0) |-> $past(active_i));

  // R8: below mode passes the base pixel
  a_r8_below_is_base: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    !$past(above_q) |-> (px_o == $past(base_px_i)));

  for (genvar k = 0; k < N_OVL; k++) begin : g_chk
    // R6: a flagged overlay is hidden
    a_r6_err_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o[k] |-> !req_o[k]);
  end
endmodule

// File: tb/test_ovl_compositor.sv
module test_ovl_compositor;
  import ovl_comp_pkg::*;
  localparam int unsigned PW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, fs, act, above, v1, v2;
  logic [COORD_W-1:0] x, y;
  logic [SIZE_W-1:0] bw, bh;
  logic [CTL_W-1:0]  c11, c12, c21, c22;
  logic [PW-1:0]     bpx, p1, p2, px;
  logic [1:0]        req, err;

  ovl_compositor #(.PIX_W(PW)) i_ovl_compositor (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .active_i(act),
    .x_i(x), .y_i(y), .base_w_i(bw), .base_h_i(bh), .ovl_above_i(above),
    .ov1_ctl1_i(c11), .ov1_ctl2_i(c12), .ov2_ctl1_i(c21), .ov2_ctl2_i(c22),
    .base_px_i(bpx), .ov1_px_i(p1), .ov2_px_i(p2),
    .ov1_vld_i(v1), .ov2_vld_i(v2),
    .px_o(px), .req_o(req), .cfg_err_o(err));

  typedef struct { int stamp; logic [PW-1:0] px; logic [1:0] req; string tag; } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model of captured settings
  bit m_on[2];
  int m_xl[2], m_xh[2], m_yl[2], m_yh[2];
  bit m_above;
  logic [1:0] m_err;

  function automatic logic [31:0] mk1(bit en, int wm1, int hm1, int code);
    return {en, 7'd0, 4'(code), 10'(hm1), 10'(wm1)};
  endfunction
  function automatic logic [31:0] mk2(int xs, int ys, int fmt);
    return {9'd0, 3'(fmt), 10'(ys), 10'(xs)};
  endfunction

  task automatic model_ovl(input int k, input logic [31:0] a, input logic [31:0] b,
                           input int w, input int h);
    int wm1, hm1, code, xs, ys, fmt, bpp;
    bit en, ok;
    wm1 = int'(a[9:0]); hm1 = int'(a[19:10]); code = int'(a[23:20]); en = a[31];
    xs = int'(b[9:0]); ys = int'(b[19:10]); fmt = int'(b[22:20]);
    ok = 1; bpp = 0;
    if (k == 0 && fmt != 0) ok = 0;
    case (fmt)
      0: case (code)
           0: bpp = 1; 1: bpp = 2; 2: bpp = 4; 3: bpp = 8;
           4: bpp = 16; 5: bpp = 18; 6: bpp = 24; 7: bpp = 32;
           default: ok = 0;
         endcase
      1: bpp = 24;
      2: bpp = 8;
      3: bpp = 4;
      4: bpp = 2;
      default: ok = 0;
    endcase
    if (ok && ((xs * bpp) % 32) != 0) ok = 0;
    if (xs + wm1 + 1 > w || ys + hm1 + 1 > h) ok = 0;
    m_on[k] = en && ok;
    m_err[k] = en && !ok;
    m_xl[k] = xs; m_xh[k] = xs + wm1; m_yl[k] = ys; m_yh[k] = ys + hm1;
  endtask

  task automatic check(input bit ok, input string tag, input string msg);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic new_frame(input logic [31:0] a1, input logic [31:0] a2,
                           input logic [31:0] b1, input logic [31:0] b2,
                           input int w, input int h, input bit abv, input string tag);
    @(negedge clk);
    act = 0; fs = 1;
    c11 = a1; c12 = a2; c21 = b1; c22 = b2;
    bw = SIZE_W'(w); bh = SIZE_W'(h); above = abv;
    model_ovl(0, a1, a2, w, h);
    model_ovl(1, b1, b2, w, h);
    m_above = abv;
    @(negedge clk);
    fs = 0;
    check(err === m_err, tag, $sformatf("cfg_err_o act=%b exp=%b", err, m_err));
  endtask

  task automatic drive_px(input int xx, input int yy, input bit a, input string tag);
    exp_t e;
    bit h[2];
    @(negedge clk);
    x = COORD_W'(xx); y = COORD_W'(yy); act = a;
    bpx = {8'h10, 8'(yy), 8'(xx)};
    p1  = {8'hA1, 8'(yy), 8'(xx)};
    p2  = {8'hB2, 8'(yy), 8'(xx)};
    v1 = !(xx == 9 && yy == 2);
    v2 = !(xx == 13 && yy == 4);
    for (int k = 0; k < 2; k++)
      h[k] = a && m_on[k] && xx >= m_xl[k] && xx <= m_xh[k] && yy >= m_yl[k] && yy <= m_yh[k];
    e.px = bpx;
    if (m_above && h[0] && v1) e.px = p1;
    if (m_above && h[1] && v2) e.px = p2;
    e.req = {h[1], h[0]};
    e.stamp = cyc;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic sweep(input int x0, input int x1, input int y0, input int y1, input string tag);
    for (int yy = y0; yy <= y1; yy++)
      for (int xx = x0; xx <= x1; xx++)
        drive_px(xx, yy, 1'b1, tag);
    @(negedge clk);
    act = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      check(px === e.px && req === e.req, e.tag,
            $sformatf("px act=%h exp=%h req act=%b exp=%b", px, e.px, req, e.req));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fs = 0; act = 0; above = 0; v1 = 0; v2 = 0;
    x = '0; y = '0; bw = '0; bh = '0;
    c11 = '0; c12 = '0; c21 = '0; c22 = '0;
    bpx = '0; p1 = '0; p2 = '0;
    m_on = '{0, 0}; m_above = 0; m_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    check(px === '0 && req === 2'b00 && err === 2'b00, "R12",
          $sformatf("px=%h req=%b err=%b exp all zero", px, req, err));
    drive_px(10, 3, 1'b1, "R12 hidden after reset");

    // overlapping windows, above mode
    new_frame(mk1(1, 7, 3, 4), mk2(8, 2, 0), mk1(1, 3, 1, 6), mk2(12, 3, 0),
              64, 48, 1, "R2 legal config");
    sweep(6, 17, 1, 6, "R1/R7/R9/R10 overlap");
    drive_px(10, 3, 1'b0, "R9 inactive");

    // changes without frame start are ignored
    @(negedge clk);
    c11 = mk1(0, 7, 3, 4); above = 0; c22 = mk2(0, 0, 0);
    sweep(6, 17, 1, 6, "R11 no capture mid-frame");

    // below mode
    new_frame(mk1(1, 7, 3, 4), mk2(8, 2, 0), mk1(1, 3, 1, 6), mk2(12, 3, 0),
              64, 48, 0, "R8 config");
    sweep(6, 17, 1, 6, "R8 below");

    // format on overlay 1, oversize overlay 2
    new_frame(mk1(1, 7, 3, 4), mk2(8, 2, 1), mk1(1, 7, 1, 6), mk2(60, 3, 0),
              64, 48, 1, "R3/R4 errors");
    sweep(6, 20, 2, 4, "R3/R4 hidden");
    sweep(58, 63, 3, 4, "R4 hidden");

    // misaligned overlay 1, planar 4:2:2 overlay 2
    new_frame(mk1(1, 3, 1, 4), mk2(3, 0, 0), mk1(1, 15, 2, 0), mk2(8, 1, 3),
              64, 48, 1, "R5 misaligned");
    sweep(0, 25, 0, 4, "R2/R5 sweep");

    // disabled bad overlay 1, illegal format overlay 2
    new_frame(mk1(0, 3, 1, 9), mk2(3, 0, 0), mk1(1, 3, 1, 0), mk2(8, 1, 5),
              64, 48, 1, "R6/R3 flags");
    sweep(0, 12, 0, 2, "R6 disabled");

    // exact fit on both overlays
    new_frame(mk1(1, 63, 47, 3), mk2(0, 0, 0), mk1(1, 7, 7, 0), mk2(56, 40, 2),
              64, 48, 1, "R4 exact fit");
    sweep(52, 63, 38, 47, "R4/R1 edge");

    // one line too tall; single-pixel 18-bit window
    new_frame(mk1(1, 0, 0, 5), mk2(16, 5, 0), mk1(1, 7, 7, 0), mk2(56, 41, 2),
              64, 48, 1, "R4 one over");
    sweep(15, 17, 4, 6, "R1 single pixel");
    sweep(55, 63, 46, 47, "R4 hidden");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule